// File: doc/BRIEF.md
# USB Full-Speed Bus State Monitor

This block watches the D+ and D- levels of a full-speed USB device port and reports what the bus is doing. Both raw lines are brought into the sampling clock domain, filtered, and classified into one of four line states. The length of each line state is counted in samples. Those run lengths decide when the block reports a bus reset, an end of packet or a suspend. A start of packet is reported as soon as the bus moves from idle to resume.

The sampling clock is expected to run at four times the bit rate, which is 48 MHz for 12 Mb/s. All thresholds are parameters counted in samples. By default a reset needs more than 120 samples of SE0, and a suspend needs more than 144000 samples of idle. A serial interface engine or a power manager uses the single-cycle event pulses and the suspend level. NRZI decoding, bit unstuffing and packet decoding belong to other blocks.

Top module: `usb_bus_monitor`

## Requirements
- R1: The line-state output is the code {D-, D+}: 00 = SE0, 01 = J (idle), 10 = K (resume), 11 = SE1. A new level on the raw pins appears on the output exactly 4 clocks after the first sampling edge that sees it, and only once both synchronized samples agree.
- R2: A level that lasts a single sample is filtered out and does not change the line-state output or raise any event.
- R3: A change from J to K raises the start-of-packet pulse for exactly one cycle, one clock after the line-state output shows K.
- R4: An SE0 run of 6 to 10 samples (1.5 to 2.5 bit times), followed by J for 4 samples, raises one end-of-packet pulse. If the J lasts 3 samples or fewer before the bus changes again, no pulse is raised.
- R5: An SE0 run of fewer than 6 samples, or of 11 to 120 samples, raises neither an end-of-packet pulse nor a reset pulse.
- R6: An SE0 run longer than RESET_SAMPLES (120) raises the bus-reset pulse exactly once per episode. A run of exactly 120 samples raises no reset pulse.
- R7: The suspend output goes high after J has been held for more than SUSPEND_SAMPLES samples. Any other line state restarts this count, so an end of packet between idle periods prevents the suspend.
- R8: While suspended, a K state clears the suspend output and raises the wake pulse for one cycle.
- R9: A bus reset detected while suspended clears the suspend output in the same cycle that the reset pulse is high, and no wake pulse is raised.
- R10: SE1 starts no event. A K that follows SE1 is not a start of packet.
- R11: While synchronous reset is high, and after it is released with idle on the bus, the line state is J, all pulses are low and the suspend output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (4x bit rate) |
| rst | input | 1 | Synchronous reset, active high |
| dpRaw | input | 1 | Raw D+ level |
| dmRaw | input | 1 | Raw D- level |
| lineState | output | 2 | Filtered line state {D-, D+} |
| sopPulse | output | 1 | Start-of-packet pulse |
| eopPulse | output | 1 | End-of-packet pulse |
| busResetPulse | output | 1 | Bus-reset pulse, once per episode |
| wakePulse | output | 1 | Wake-up from suspend by resume |
| suspended | output | 1 | Suspend state level |

## Verification
The assertions check on every cycle that a filtered state only ever takes the value the synchronizer has been holding, and that start-of-packet, end-of-packet and reset pulses never occur together. They also check that a reset pulse is never longer than one cycle, that suspend is only entered from idle, and that a wake or a reset while suspended really leaves suspend. The exact thresholds need the bench's scenarios: the 4-clock latency, the edges of the end-of-packet window, the 120-sample reset boundary, glitch rejection, and the idle timer being restarted by traffic. Only these scenarios show them.

// File: rtl/usbmon_pkg.sv
package usbmon_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } lineCode_t;

  // strobes from the line datapath to the event control
  typedef struct packed {
    lineCode_t curLine;
    lineCode_t prevLine;
    logic      runStart;    // first cycle of a new line state
    logic      resetHit;    // SE0 just exceeded the reset threshold
    logic      idleHit;     // J just exceeded the suspend threshold
    logic      eopIdleHit;  // qualifying SE0 followed by one full idle bit
  } lineEvt_t;

endpackage

// File: rtl/usbmon_line_path.sv
module usbmon_line_path
  import usbmon_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 4,
  parameter int RESET_SAMPLES   = 120,
  parameter int SUSPEND_SAMPLES = 144000
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     dpRaw,
  input  logic     dmRaw,
  output lineEvt_t evt
);

  localparam int RunCap = ((SUSPEND_SAMPLES > RESET_SAMPLES) ? SUSPEND_SAMPLES : RESET_SAMPLES) + 2;
  localparam int RunW   = $clog2(RunCap + 1);
  localparam int EopMin = SAMPLES_PER_BIT + SAMPLES_PER_BIT / 2;
  localparam int EopMax = 2 * SAMPLES_PER_BIT + SAMPLES_PER_BIT / 2;

  logic [1:0]      syncA, syncB, syncC;
  lineCode_t       curLine, prevLine;
  logic [RunW-1:0] runLen, prevRun;
  logic            acceptNew;

  // two-flop synchronizer plus one history stage for the stability filter
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= LS_J;
      syncB <= LS_J;
      syncC <= LS_J;
    end else begin
      syncA <= {dmRaw, dpRaw};
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign acceptNew = (syncB == syncC) && (lineCode_t'(syncB) != curLine);

  always_ff @(posedge clk) begin
    if (rst) begin
      curLine  <= LS_J;
      prevLine <= LS_SE1;
      runLen   <= RunW'(1);
      prevRun  <= '0;
    end else if (acceptNew) begin
      prevLine <= curLine;
      prevRun  <= runLen;
      curLine  <= lineCode_t'(syncB);
      runLen   <= RunW'(1);
    end else if (runLen != RunW'(RunCap)) begin
      runLen <= runLen + RunW'(1);
    end
  end

  always_comb begin
    evt.curLine    = curLine;
    evt.prevLine   = prevLine;
    evt.runStart   = (runLen == RunW'(1));
    evt.resetHit   = (curLine == LS_SE0) && (runLen == RunW'(RESET_SAMPLES + 1));
    evt.idleHit    = (curLine == LS_J) && (runLen == RunW'(SUSPEND_SAMPLES + 1));
    evt.eopIdleHit = (curLine == LS_J) && (runLen == RunW'(SAMPLES_PER_BIT)) &&
                     (prevLine == LS_SE0) &&
                     (prevRun >= RunW'(EopMin)) && (prevRun <= RunW'(EopMax));
  end

  // R1
  accept_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(curLine) |-> (curLine == lineCode_t'($past(syncB))) && $past(syncB == syncC));

endmodule

// File: rtl/usbmon_event_ctrl.sv
module usbmon_event_ctrl
  import usbmon_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  lineEvt_t evt,
  output logic     sopPulse,
  output logic     eopPulse,
  output logic     busResetPulse,
  output logic     wakePulse,
  output logic     suspended
);

  typedef enum logic {PWR_AWAKE, PWR_ASLEEP} pwr_t;
  pwr_t pwrState;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwrState      <= PWR_AWAKE;
      sopPulse      <= 1'b0;
      eopPulse      <= 1'b0;
      busResetPulse <= 1'b0;
      wakePulse     <= 1'b0;
    end else begin
      sopPulse      <= evt.runStart && (evt.curLine == LS_K) && (evt.prevLine == LS_J);
      eopPulse      <= evt.eopIdleHit;
      busResetPulse <= evt.resetHit;
      wakePulse     <= 1'b0;
      case (pwrState)
        PWR_AWAKE:
          if (evt.idleHit) pwrState <= PWR_ASLEEP;
        PWR_ASLEEP:
          if (evt.resetHit) begin
            pwrState <= PWR_AWAKE;
          end else if (evt.curLine == LS_K) begin
            pwrState  <= PWR_AWAKE;
            wakePulse <= 1'b1;
          end
        default: pwrState <= PWR_AWAKE;
      endcase
    end
  end

  assign suspended = (pwrState == PWR_ASLEEP);

  // R6
  reset_once_chk: assert property (@(posedge clk) disable iff (rst)
    busResetPulse |=> !busResetPulse);

  // R3
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sopPulse, eopPulse, busResetPulse}));

  // R7
  suspend_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(suspended) |-> ($past(evt.curLine) == LS_J));

  // R8
  wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
    wakePulse |-> (!suspended && $past(suspended)));

  // R9
  reset_wakes_chk: assert property (@(posedge clk) disable iff (rst)
    (busResetPulse && $past(suspended)) |-> (!suspended && !wakePulse));

endmodule

// File: rtl/usb_bus_monitor.sv
module usb_bus_monitor
  import usbmon_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 4,
  parameter int RESET_SAMPLES   = 120,
  parameter int SUSPEND_SAMPLES = 144000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dpRaw,
  input  logic       dmRaw,
  output logic [1:0] lineState,
  output logic       sopPulse,
  output logic       eopPulse,
  output logic       busResetPulse,
  output logic       wakePulse,
  output logic       suspended
);

  lineEvt_t evt;

  usbmon_line_path #(
    .SAMPLES_PER_BIT(SAMPLES_PER_BIT),
    .RESET_SAMPLES  (RESET_SAMPLES),
    .SUSPEND_SAMPLES(SUSPEND_SAMPLES)
  ) u_path (
    .clk  (clk),
    .rst  (rst),
    .dpRaw(dpRaw),
    .dmRaw(dmRaw),
    .evt  (evt)
  );

  usbmon_event_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .evt          (evt),
    .sopPulse     (sopPulse),
    .eopPulse     (eopPulse),
    .busResetPulse(busResetPulse),
    .wakePulse    (wakePulse),
    .suspended    (suspended)
  );

  assign lineState = evt.curLine;

endmodule

// File: tb/usb_bus_monitor_bench.sv
module usb_bus_monitor_bench;

  localparam int SuspTh = 300;
  localparam int NVec   = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dpRaw = 1'b1;
  logic dmRaw = 1'b0;
  logic [1:0] lineState;
  logic sopPulse, eopPulse, busResetPulse, wakePulse, suspended;

  int checks = 0;
  int fails  = 0;
  int sopCnt = 0, eopCnt = 0, rstCnt = 0, wakeCnt = 0;
  int rstInSusp = 0;
  logic lastSusp = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usb_bus_monitor #(.SUSPEND_SAMPLES(SuspTh)) u_usb_bus_monitor (
    .clk(clk), .rst(rst), .dpRaw(dpRaw), .dmRaw(dmRaw),
    .lineState(lineState), .sopPulse(sopPulse), .eopPulse(eopPulse),
    .busResetPulse(busResetPulse), .wakePulse(wakePulse), .suspended(suspended)
  );

  always @(negedge clk) begin
    if (sopPulse) sopCnt++;
    if (eopPulse) eopCnt++;
    if (busResetPulse) rstCnt++;
    if (wakePulse) wakeCnt++;
    if (busResetPulse && lastSusp && !suspended && !wakePulse) rstInSusp++;
    lastSusp = suspended;
  end

  // segments {code,len} x4, then expected sop, eop, reset pulses, requirement
  localparam int VEC [NVec][12] = '{
    '{1,10, 2,8,   1,20, 1,1, 1,0,0, 3},   // R3 plain J->K
    '{1,8,  0,8,   1,4,  2,4, 1,1,0, 4},   // R4 nominal end of packet
    '{1,8,  0,8,   1,3,  2,5, 1,0,0, 4},   // R4 idle bit too short
    '{1,8,  0,6,   1,4,  2,4, 1,1,0, 4},   // R4 shortest window
    '{1,8,  0,10,  1,4,  2,4, 1,1,0, 4},   // R4 longest window
    '{1,8,  0,5,   1,6,  2,4, 1,0,0, 5},   // R5 SE0 too short
    '{1,8,  0,11,  1,6,  2,4, 1,0,0, 5},   // R5 SE0 just past window
    '{1,8,  0,40,  1,6,  2,4, 1,0,0, 5},   // R5 mid-length SE0
    '{1,8,  0,120, 1,6,  2,4, 1,0,0, 6},   // R6 exactly threshold
    '{1,8,  0,121, 1,6,  2,4, 1,0,1, 6},   // R6 one past threshold
    '{1,8,  3,5,   2,5,  1,10,0,0,0, 10},  // R10 SE1 then K
    '{1,8,  2,1,   1,8,  1,4, 0,0,0, 2},   // R2 one-sample K
    '{1,8,  0,1,   1,8,  1,4, 0,0,0, 2}    // R2 one-sample SE0
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int code, input int n);
    dpRaw = code[0];
    dmRaw = code[1];
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    dpRaw = 1'b1;
    dmRaw = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    @(negedge clk);
    doReset();
    // R11 reset state
    check(lineState == 2'b01, "R11 lineState", int'(lineState), 1);
    check({sopPulse, eopPulse, busResetPulse, wakePulse, suspended} == 5'b0, "R11 outputs",
          int'({sopPulse, eopPulse, busResetPulse, wakePulse, suspended}), 0);

    // table of vectors
    for (int v = 0; v < NVec; v++) begin
      int s0, e0, r0;
      doReset();
      s0 = sopCnt; e0 = eopCnt; r0 = rstCnt;
      for (int k = 0; k < 4; k++) drive(VEC[v][2*k], VEC[v][2*k+1]);
      repeat (8) @(negedge clk);
      check(sopCnt - s0 == VEC[v][8], $sformatf("R%0d vec%0d sop", VEC[v][11], v), sopCnt - s0, VEC[v][8]);
      check(eopCnt - e0 == VEC[v][9], $sformatf("R%0d vec%0d eop", VEC[v][11], v), eopCnt - e0, VEC[v][9]);
      check(rstCnt - r0 == VEC[v][10], $sformatf("R%0d vec%0d reset", VEC[v][11], v), rstCnt - r0, VEC[v][10]);
    end

    // R1 latency and code mapping, R3 pulse timing
    doReset();
    repeat (4) @(negedge clk);
    dpRaw = 1'b0; dmRaw = 1'b1;
    repeat (3) @(negedge clk);
    check(lineState == 2'b01, "R1 before latency", int'(lineState), 1);
    @(negedge clk);
    check(lineState == 2'b10, "R1 K after 4 clocks", int'(lineState), 2);
    check(sopPulse == 1'b0, "R3 sop not yet", int'(sopPulse), 0);
    @(negedge clk);
    check(sopPulse == 1'b1, "R3 sop one clock later", int'(sopPulse), 1);
    @(negedge clk);
    check(sopPulse == 1'b0, "R3 sop single cycle", int'(sopPulse), 0);
    drive(0, 6);
    check(lineState == 2'b00, "R1 SE0 code", int'(lineState), 0);
    drive(3, 6);
    check(lineState == 2'b11, "R1 SE1 code", int'(lineState), 3);

    // R7 suspend entry and idle timer restart
    doReset();
    repeat (250) @(negedge clk);
    check(suspended == 1'b0, "R7 not yet suspended", int'(suspended), 0);
    repeat (80) @(negedge clk);
    check(suspended == 1'b1, "R7 suspended after idle", int'(suspended), 1);
    doReset();
    drive(1, 200);
    drive(0, 8);
    drive(1, 200);
    check(suspended == 1'b0, "R7 traffic restarts idle timer", int'(suspended), 0);
    drive(1, 150);
    check(suspended == 1'b1, "R7 suspended after long idle", int'(suspended), 1);

    // R8 wake by resume
    begin
      int w0;
      w0 = wakeCnt;
      drive(2, 10);
      check(wakeCnt - w0 == 1, "R8 wake pulse", wakeCnt - w0, 1);
      check(suspended == 1'b0, "R8 suspend cleared", int'(suspended), 0);
    end

    // R9 reset while suspended
    begin
      int w0, r0;
      drive(1, 400);
      check(suspended == 1'b1, "R9 suspended before reset", int'(suspended), 1);
      w0 = wakeCnt; r0 = rstInSusp;
      drive(0, 130);
      drive(1, 8);
      check(rstInSusp - r0 == 1, "R9 reset clears suspend same cycle", rstInSusp - r0, 1);
      check(wakeCnt - w0 == 0, "R9 no wake pulse", wakeCnt - w0, 0);
      check(suspended == 1'b0, "R9 not suspended", int'(suspended), 0);
    end

    finishRun();
  end

endmodule